// File: doc/BRIEF.md
# 16-bit Arithmetic Unit with Extension Register

This block performs the two-operand data operations of a small 16-bit processor. Each operation takes a 5-bit operation code, a destination operand value `b`, a source operand value `a` and the current value of the extension register. It produces the new destination value, the new extension register value and, for test operations, a flag telling the sequencer whether the test holds. Fetching operands, routing the results back to the register file and skipping instructions belong to the surrounding pipeline.

The extension register widens the arithmetic. After an add it holds the carry. After a subtract it holds the borrow as all ones. After a multiply it holds the upper product word. After a divide it holds the fractional part of the quotient. After a shift it holds the bits shifted out. A zero divisor never traps: the quotient, the remainder and the fraction all read as zero.

One operation is accepted per clock while `in_valid` is high. Results are registered and appear on the outputs one cycle later, marked by `out_valid`. Between operations the outputs keep their last value.

Top module: `ovf_alu`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `res_b`, `res_ex` and `cond_true` to 0. An operation presented with `in_valid` high at a rising edge shows its results at the next edge, with `out_valid` high for exactly that one cycle.
- R2: While `in_valid` is low, `out_valid` is 0 and `res_b`, `res_ex` and `cond_true` keep their previous values, whatever the other inputs do.
- R3: Add (code 0x02) gives b+a. Add-with-carry (code 0x1A) gives b+a+EX. Both set EX to 0x0001 when the true sum exceeds 0xFFFF and to 0x0000 otherwise.
- R4: Subtract (code 0x03) gives b-a. Subtract-with-carry (code 0x1B) gives b-a+EX. Both set EX to 0xFFFF when the true result is negative and to 0x0000 otherwise, including when it exceeds 0xFFFF.
- R5: Unsigned multiply (code 0x04) and signed multiply (code 0x05) return the low product word as b and the high product word as EX.
- R6: Unsigned divide (code 0x06) with a nonzero divisor returns b/a and sets EX to the low word of (b·65536)/a. With a zero divisor both outputs are 0.
- R7: Signed divide (code 0x07) truncates toward zero and sets EX to the low word of (b·65536)/a, computed as signed values with no overflow. With a zero divisor both outputs are 0. The quotient 0x8000 / 0xFFFF gives b = 0x8000.
- R8: Unsigned remainder (code 0x08) and signed remainder (code 0x09) return 0 for a zero divisor. The signed result takes the sign of the dividend. Both leave EX unchanged.
- R9: Logical right shift (code 0x0D) shifts the 32-bit word {b, 0x0000} right by a, then returns its upper half as b and its lower half as EX. Left shift (code 0x0F) shifts {0x0000, b} left by a, then returns its lower half as b and its upper half as EX. Any shift amount, including 16 and above, follows these formulas.
- R10: Arithmetic right shift (code 0x0E) shifts the signed 32-bit word {b, 0x0000} right by a, filling with the sign, then returns its upper half as b and its lower half as EX. For amounts of 16 or more, b is 0x0000 or 0xFFFF according to the sign of b.
- R11: Copy (code 0x01) returns a. AND (0x0A), OR (0x0B) and XOR (0x0C) return the bitwise result. All four leave EX unchanged.
- R12: The test codes 0x10 to 0x17 set `cond_true` for: bits in common, no bits in common, equal, not equal, unsigned greater, signed greater, unsigned less, signed less, in that code order. They return b and EX unchanged.
- R13: `cond_true` is 0 for every code outside 0x10 to 0x17. Codes with no operation assigned (0x00, 0x18, 0x19, 0x1C to 0x1F) return b and EX unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 5 | Operation code |
| opnd_b | input | 16 | Destination operand value |
| opnd_a | input | 16 | Source operand value |
| ex_in | input | 16 | Current extension register value |
| out_valid | output | 1 | Results below belong to the operation of the previous cycle |
| res_b | output | 16 | New destination value |
| res_ex | output | 16 | New extension register value |
| cond_true | output | 1 | Test operation holds |

## Verification
The hardest cases to reach are the edges of the wide intermediate results. These include a subtract-with-carry that overflows instead of underflowing, an add-with-carry of three all-ones words, a signed divide of the most negative value by minus one, and shifts by 16, 17, 20 and 40 that move the whole operand into the extension word or beyond it. Directed tasks place these exact operand triples on the ports. They also repeat each zero-divisor case with a nonzero incoming extension value, so a result that leaked through would be seen.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;

  localparam int OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_COPY = 5'h01,
    OP_ADD  = 5'h02,
    OP_SUB  = 5'h03,
    OP_MULU = 5'h04,
    OP_MULS = 5'h05,
    OP_DIVU = 5'h06,
    OP_DIVS = 5'h07,
    OP_REMU = 5'h08,
    OP_REMS = 5'h09,
    OP_AND  = 5'h0A,
    OP_OR   = 5'h0B,
    OP_XOR  = 5'h0C,
    OP_SRL  = 5'h0D,
    OP_SRA  = 5'h0E,
    OP_SLL  = 5'h0F,
    OP_TBIT = 5'h10,
    OP_TCLR = 5'h11,
    OP_TEQ  = 5'h12,
    OP_TNE  = 5'h13,
    OP_TGTU = 5'h14,
    OP_TGTS = 5'h15,
    OP_TLTU = 5'h16,
    OP_TLTS = 5'h17,
    OP_ADDC = 5'h1A,
    OP_SUBC = 5'h1B
  } op_e;

endpackage

// File: rtl/ovf_alu_addsub.sv
module ovf_alu_addsub
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  input  logic [W-1:0] ex,
  output logic [W-1:0] sum_res,
  output logic [W-1:0] sum_ex
);
  // two guard bits: one for carry up to 3*max, one for sign of borrow
  localparam int XW = W + 2;

  logic [XW-1:0] bx, ax, exx, acc;
  logic [W-1:0]  one_w;

  assign bx    = {2'b00, b};
  assign ax    = {2'b00, a};
  assign exx   = {2'b00, ex};
  assign one_w = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    acc    = bx + ax;
    sum_ex = '0;
    case (op)
      OP_ADD: begin
        acc    = bx + ax;
        sum_ex = (acc[XW-1:W] != 2'b00) ? one_w : '0;
      end
      OP_ADDC: begin
        acc    = bx + ax + exx;
        sum_ex = (acc[XW-1:W] != 2'b00) ? one_w : '0;
      end
      OP_SUB: begin
        acc    = bx - ax;
        sum_ex = acc[XW-1] ? '1 : '0;
      end
      OP_SUBC: begin
        acc    = bx - ax + exx;
        sum_ex = acc[XW-1] ? '1 : '0;
      end
      default: begin
        acc    = bx + ax;
        sum_ex = '0;
      end
    endcase
    sum_res = acc[W-1:0];
  end
endmodule

// File: rtl/ovf_alu_muldiv.sv
module ovf_alu_muldiv
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  input  logic [W-1:0] ex,
  output logic [W-1:0] md_res,
  output logic [W-1:0] md_ex
);
  localparam int PW = 2 * W;
  localparam int DW = 2 * W + 2;

  logic                 a_zero;
  logic [W-1:0]         a_nz;
  logic [PW-1:0]        prod_u;
  logic signed [PW-1:0] pb, pa, prod_s;
  logic signed [DW-1:0] sb, sa, sb_sh;
  logic [W-1:0]         q_u, f_u, r_u, q_s, f_s, r_s;

  assign a_zero = (a == '0);
  // substitute divisor keeps every divider free of a zero divide
  assign a_nz   = a_zero ? {{(W-1){1'b0}}, 1'b1} : a;

  assign prod_u = {{W{1'b0}}, b} * {{W{1'b0}}, a};
  assign pb     = {{W{b[W-1]}}, b};
  assign pa     = {{W{a[W-1]}}, a};
  assign prod_s = pb * pa;

  assign sb     = {{(DW-W){b[W-1]}}, b};
  assign sa     = {{(DW-W){a_nz[W-1]}}, a_nz};
  assign sb_sh  = sb <<< W;

  assign q_u = b / a_nz;
  assign f_u = W'({b, {W{1'b0}}} / {{W{1'b0}}, a_nz});
  assign r_u = b % a_nz;
  assign q_s = W'(sb / sa);
  assign f_s = W'(sb_sh / sa);
  assign r_s = W'(sb % sa);

  always_comb begin
    md_res = '0;
    md_ex  = ex;
    case (op)
      OP_MULU: begin md_res = prod_u[W-1:0]; md_ex = prod_u[PW-1:W]; end
      OP_MULS: begin md_res = prod_s[W-1:0]; md_ex = prod_s[PW-1:W]; end
      OP_DIVU: begin
        md_res = a_zero ? '0 : q_u;
        md_ex  = a_zero ? '0 : f_u;
      end
      OP_DIVS: begin
        md_res = a_zero ? '0 : q_s;
        md_ex  = a_zero ? '0 : f_s;
      end
      OP_REMU: md_res = a_zero ? '0 : r_u;
      OP_REMS: md_res = a_zero ? '0 : r_s;
      default: begin md_res = '0; md_ex = ex; end
    endcase
  end
endmodule

// File: rtl/ovf_alu_shift.sv
module ovf_alu_shift
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  output logic [W-1:0] sh_res,
  output logic [W-1:0] sh_ex
);
  localparam int SW = 2 * W;

  logic [SW-1:0]        up_word, lo_word, wide;
  logic signed [SW-1:0] up_signed;

  assign up_word   = {b, {W{1'b0}}};
  assign lo_word   = {{W{1'b0}}, b};
  assign up_signed = up_word;

  always_comb begin
    wide   = '0;
    sh_res = '0;
    sh_ex  = '0;
    case (op)
      OP_SRL: begin
        wide   = up_word >> a;
        sh_res = wide[SW-1:W];
        sh_ex  = wide[W-1:0];
      end
      OP_SRA: begin
        wide   = up_signed >>> a;
        sh_res = wide[SW-1:W];
        sh_ex  = wide[W-1:0];
      end
      OP_SLL: begin
        wide   = lo_word << a;
        sh_res = wide[W-1:0];
        sh_ex  = wide[SW-1:W];
      end
      default: begin
        wide   = '0;
        sh_res = '0;
        sh_ex  = '0;
      end
    endcase
  end
endmodule

// File: rtl/ovf_alu_cmp.sv
module ovf_alu_cmp
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  output logic         hit
);
  always_comb begin
    case (op)
      OP_TBIT: hit = |(b & a);
      OP_TCLR: hit = ~|(b & a);
      OP_TEQ:  hit = (b == a);
      OP_TNE:  hit = (b != a);
      OP_TGTU: hit = (b > a);
      OP_TGTS: hit = ($signed(b) > $signed(a));
      OP_TLTU: hit = (b < a);
      OP_TLTS: hit = ($signed(b) < $signed(a));
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OPC_W-1:0] opcode,
  input  logic [W-1:0]     opnd_b,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     ex_in,
  output logic             out_valid,
  output logic [W-1:0]     res_b,
  output logic [W-1:0]     res_ex,
  output logic             cond_true
);
  op_e          op;
  logic [W-1:0] as_res, as_ex, md_res, md_ex, sh_res, sh_ex;
  logic         cmp_hit;
  logic [W-1:0] nxt_b, nxt_ex;

  assign op = op_e'(opcode);

  ovf_alu_addsub #(.W(W)) u_addsub (
    .op(op), .b(opnd_b), .a(opnd_a), .ex(ex_in),
    .sum_res(as_res), .sum_ex(as_ex)
  );

  ovf_alu_muldiv #(.W(W)) u_muldiv (
    .op(op), .b(opnd_b), .a(opnd_a), .ex(ex_in),
    .md_res(md_res), .md_ex(md_ex)
  );

  ovf_alu_shift #(.W(W)) u_shift (
    .op(op), .b(opnd_b), .a(opnd_a),
    .sh_res(sh_res), .sh_ex(sh_ex)
  );

  ovf_alu_cmp #(.W(W)) u_cmp (
    .op(op), .b(opnd_b), .a(opnd_a), .hit(cmp_hit)
  );

  always_comb begin
    nxt_b  = opnd_b;
    nxt_ex = ex_in;
    case (op)
      OP_COPY: nxt_b = opnd_a;
      OP_AND:  nxt_b = opnd_b & opnd_a;
      OP_OR:   nxt_b = opnd_b | opnd_a;
      OP_XOR:  nxt_b = opnd_b ^ opnd_a;
      OP_ADD, OP_SUB, OP_ADDC, OP_SUBC: begin
        nxt_b  = as_res;
        nxt_ex = as_ex;
      end
      OP_MULU, OP_MULS, OP_DIVU, OP_DIVS, OP_REMU, OP_REMS: begin
        nxt_b  = md_res;
        nxt_ex = md_ex;
      end
      OP_SRL, OP_SRA, OP_SLL: begin
        nxt_b  = sh_res;
        nxt_ex = sh_ex;
      end
      default: begin
        nxt_b  = opnd_b;
        nxt_ex = ex_in;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_b     <= '0;
      res_ex    <= '0;
      cond_true <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_b     <= nxt_b;
        res_ex    <= nxt_ex;
        cond_true <= cmp_hit;
      end
    end
  end

  // R1: an accepted operation is flagged on the following cycle
  p_valid_next_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2: idle cycles leave every result untouched
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(res_b) && $stable(res_ex) && $stable(cond_true)));

  // R3: carry word is only ever 0 or 1
  p_carry_word_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opcode == OP_ADD || opcode == OP_ADDC)) |=> (res_ex <= 1));

  // R4: borrow word is all zeros or all ones
  p_borrow_word_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opcode == OP_SUB || opcode == OP_SUBC)) |=> (res_ex == '0 || res_ex == '1));

  // R6: zero divisor yields zero quotient and fraction
  p_div_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_DIVU && opnd_a == '0) |=> (res_b == '0 && res_ex == '0));

  // R7: signed zero divisor yields zeros as well
  p_sdiv_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_DIVS && opnd_a == '0) |=> (res_b == '0 && res_ex == '0));

  // R11: logic and copy keep the extension word
  p_logic_keeps_ex_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR || opcode == OP_COPY))
    |=> (res_ex == $past(ex_in)));

  // R13: only the test codes raise the flag
  p_flag_scope_r13: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(opcode inside {[5'h10:5'h17]})) |=> !cond_true);

  // R12: test codes pass b through unchanged
  p_test_keeps_b_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opcode inside {[5'h10:5'h17]})) |=> (res_b == $past(opnd_b)));
endmodule

// File: tb/sim_ovf_alu.sv
`timescale 1ns/1ps
module sim_ovf_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  opcode = '0;
  logic [15:0] opnd_b = '0, opnd_a = '0, ex_in = '0;
  logic        out_valid, cond_true;
  logic [15:0] res_b, res_ex;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ovf_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .opnd_b(opnd_b), .opnd_a(opnd_a), .ex_in(ex_in),
    .out_valid(out_valid), .res_b(res_b), .res_ex(res_ex), .cond_true(cond_true)
  );

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the result edge
  task automatic do_op(input string req, input logic [4:0] op, input logic [15:0] b,
                       input logic [15:0] a, input logic [15:0] ex,
                       input logic [15:0] eb, input logic [15:0] eex, input logic ec);
    opcode = op; opnd_b = b; opnd_a = a; ex_in = ex; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "valid", {15'd0, out_valid}, 16'd1);
    chk(req, "b", res_b, eb);
    chk(req, "ex", res_ex, eex);
    chk(req, "cond", {15'd0, cond_true}, {15'd0, ec});
  endtask

  task automatic t_reset_r1();
    chk("R1", "reset valid", {15'd0, out_valid}, 16'd0);
    chk("R1", "reset b", res_b, 16'h0000);
    chk("R1", "reset ex", res_ex, 16'h0000);
    chk("R1", "reset cond", {15'd0, cond_true}, 16'd0);
    do_op("R1", 5'h01, 16'h0000, 16'h00A5, 16'h0000, 16'h00A5, 16'h0000, 1'b0);
    @(negedge clk);
    chk("R1", "single-cycle valid", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_hold_r2();
    do_op("R2", 5'h02, 16'h1000, 16'h0234, 16'h0000, 16'h1234, 16'h0000, 1'b0);
    for (int i = 0; i < 3; i++) begin
      opcode = 5'h0F; opnd_b = 16'hFFFF; opnd_a = 16'h0004; ex_in = 16'h9999;
      @(negedge clk);
      chk("R2", "idle valid", {15'd0, out_valid}, 16'd0);
      chk("R2", "idle b", res_b, 16'h1234);
      chk("R2", "idle ex", res_ex, 16'h0000);
    end
  endtask

  task automatic t_add_r3();
    do_op("R3", 5'h02, 16'hFFFF, 16'h0002, 16'h0000, 16'h0001, 16'h0001, 1'b0);
    do_op("R3", 5'h02, 16'h1234, 16'h1111, 16'h5555, 16'h2345, 16'h0000, 1'b0);
    do_op("R3", 5'h1A, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFD, 16'h0001, 1'b0);
    do_op("R3", 5'h1A, 16'h0001, 16'h0002, 16'h0003, 16'h0006, 16'h0000, 1'b0);
  endtask

  task automatic t_sub_r4();
    do_op("R4", 5'h03, 16'h0003, 16'h0005, 16'h0000, 16'hFFFE, 16'hFFFF, 1'b0);
    do_op("R4", 5'h03, 16'h0005, 16'h0003, 16'h1234, 16'h0002, 16'h0000, 1'b0);
    do_op("R4", 5'h1B, 16'h0003, 16'h0005, 16'h0001, 16'hFFFF, 16'hFFFF, 1'b0);
    do_op("R4", 5'h1B, 16'h0003, 16'h0005, 16'h0002, 16'h0000, 16'h0000, 1'b0);
    do_op("R4", 5'h1B, 16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFE, 16'h0000, 1'b0);
  endtask

  task automatic t_mul_r5();
    do_op("R5", 5'h04, 16'h1234, 16'h0100, 16'h0000, 16'h3400, 16'h0012, 1'b0);
    do_op("R5", 5'h04, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0001, 16'hFFFE, 1'b0);
    do_op("R5", 5'h05, 16'hFFFF, 16'hFFFF, 16'h7777, 16'h0001, 16'h0000, 1'b0);
    do_op("R5", 5'h05, 16'hFFFE, 16'h0003, 16'h0000, 16'hFFFA, 16'hFFFF, 1'b0);
  endtask

  task automatic t_div_r6();
    do_op("R6", 5'h06, 16'h0007, 16'h0002, 16'h0000, 16'h0003, 16'h8000, 1'b0);
    do_op("R6", 5'h06, 16'h0001, 16'h0003, 16'h0000, 16'h0000, 16'h5555, 1'b0);
    do_op("R6", 5'h06, 16'h1234, 16'h0000, 16'h7777, 16'h0000, 16'h0000, 1'b0);
  endtask

  task automatic t_sdiv_r7();
    do_op("R7", 5'h07, 16'hFFF9, 16'h0002, 16'h0000, 16'hFFFD, 16'h8000, 1'b0);
    do_op("R7", 5'h07, 16'h0007, 16'hFFFE, 16'h0000, 16'hFFFD, 16'h8000, 1'b0);
    do_op("R7", 5'h07, 16'h8000, 16'hFFFF, 16'h0000, 16'h8000, 16'h0000, 1'b0);
    do_op("R7", 5'h07, 16'h4321, 16'h0000, 16'h7777, 16'h0000, 16'h0000, 1'b0);
  endtask

  task automatic t_rem_r8();
    do_op("R8", 5'h08, 16'd17, 16'd5, 16'hABCD, 16'd2, 16'hABCD, 1'b0);
    do_op("R8", 5'h08, 16'h1234, 16'h0000, 16'h1111, 16'h0000, 16'h1111, 1'b0);
    do_op("R8", 5'h09, 16'hFFF9, 16'h0010, 16'h2222, 16'hFFF9, 16'h2222, 1'b0);
    do_op("R8", 5'h09, 16'h0007, 16'hFFFC, 16'h0000, 16'h0003, 16'h0000, 1'b0);
    do_op("R8", 5'h09, 16'h8001, 16'h0000, 16'h3333, 16'h0000, 16'h3333, 1'b0);
  endtask

  task automatic t_shift_r9();
    do_op("R9", 5'h0D, 16'h8001, 16'd1,  16'h0000, 16'h4000, 16'h8000, 1'b0);
    do_op("R9", 5'h0D, 16'h1234, 16'd16, 16'h0000, 16'h0000, 16'h1234, 1'b0);
    do_op("R9", 5'h0D, 16'h1234, 16'd20, 16'h0000, 16'h0000, 16'h0123, 1'b0);
    do_op("R9", 5'h0F, 16'h8001, 16'd1,  16'h0000, 16'h0002, 16'h0001, 1'b0);
    do_op("R9", 5'h0F, 16'h1234, 16'd16, 16'h0000, 16'h0000, 16'h1234, 1'b0);
    do_op("R9", 5'h0F, 16'h1234, 16'd40, 16'hFFFF, 16'h0000, 16'h0000, 1'b0);
  endtask

  task automatic t_asr_r10();
    do_op("R10", 5'h0E, 16'h8000, 16'd4,  16'h0000, 16'hF800, 16'h0000, 1'b0);
    do_op("R10", 5'h0E, 16'h8001, 16'd1,  16'h0000, 16'hC000, 16'h8000, 1'b0);
    do_op("R10", 5'h0E, 16'h8000, 16'd20, 16'h0000, 16'hFFFF, 16'hF800, 1'b0);
    do_op("R10", 5'h0E, 16'h4000, 16'd17, 16'h0000, 16'h0000, 16'h2000, 1'b0);
  endtask

  task automatic t_logic_r11();
    do_op("R11", 5'h01, 16'h1111, 16'hBEEF, 16'h4242, 16'hBEEF, 16'h4242, 1'b0);
    do_op("R11", 5'h0A, 16'hF0F0, 16'h3C3C, 16'h4242, 16'h3030, 16'h4242, 1'b0);
    do_op("R11", 5'h0B, 16'hF0F0, 16'h3C3C, 16'h0101, 16'hFCFC, 16'h0101, 1'b0);
    do_op("R11", 5'h0C, 16'hF0F0, 16'h3C3C, 16'hFFFF, 16'hCCCC, 16'hFFFF, 1'b0);
  endtask

  task automatic t_test_r12();
    do_op("R12", 5'h10, 16'h0F0F, 16'h00F0, 16'h5A5A, 16'h0F0F, 16'h5A5A, 1'b0);
    do_op("R12", 5'h10, 16'h0F0F, 16'h0101, 16'h5A5A, 16'h0F0F, 16'h5A5A, 1'b1);
    do_op("R12", 5'h11, 16'h0F0F, 16'h00F0, 16'h0000, 16'h0F0F, 16'h0000, 1'b1);
    do_op("R12", 5'h11, 16'h0F0F, 16'h0101, 16'h0000, 16'h0F0F, 16'h0000, 1'b0);
    do_op("R12", 5'h12, 16'h0005, 16'h0005, 16'h0000, 16'h0005, 16'h0000, 1'b1);
    do_op("R12", 5'h13, 16'h0005, 16'h0005, 16'h0000, 16'h0005, 16'h0000, 1'b0);
    do_op("R12", 5'h14, 16'h8000, 16'h0001, 16'h0000, 16'h8000, 16'h0000, 1'b1);
    do_op("R12", 5'h15, 16'h8000, 16'h0001, 16'h0000, 16'h8000, 16'h0000, 1'b0);
    do_op("R12", 5'h16, 16'h8000, 16'h0001, 16'h0000, 16'h8000, 16'h0000, 1'b0);
    do_op("R12", 5'h17, 16'h8000, 16'h0001, 16'h0000, 16'h8000, 16'h0000, 1'b1);
  endtask

  task automatic t_unused_r13();
    logic [4:0] codes [6] = '{5'h00, 5'h18, 5'h19, 5'h1C, 5'h1D, 5'h1F};
    for (int i = 0; i < 6; i++)
      do_op("R13", codes[i], 16'hA5A5 ^ 16'(i), 16'h0003, 16'hC3C3, 16'hA5A5 ^ 16'(i), 16'hC3C3, 1'b0);
    // a true test followed by an add: flag must drop
    do_op("R13", 5'h12, 16'h0009, 16'h0009, 16'h0000, 16'h0009, 16'h0000, 1'b1);
    do_op("R13", 5'h02, 16'h0009, 16'h0009, 16'h0000, 16'h0012, 16'h0000, 1'b0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_r1();
    t_hold_r2();
    t_add_r3();
    t_sub_r4();
    t_mul_r5();
    t_div_r6();
    t_sdiv_r7();
    t_rem_r8();
    t_shift_r9();
    t_asr_r10();
    t_logic_r11();
    t_test_r12();
    t_unused_r13();
    @(negedge clk);
    report();
  end
endmodule